// File: doc/BRIEF.md
# ADC Multiplexer Channel Sequencer

This block steers the select lines of two banks of external analog multiplexers that feed a multi-channel ADC. The ADC scan walks through channel indices 0 to 7. Each completed conversion is signalled by a one-cycle done strobe, together with the index that was just read. When the scan finishes the last channel served by a bank, the block advances that bank's 3-bit select field in the output pin word. The next pass of the scan then samples the next analog input behind each multiplexer.

The pin word is handled as a read-modify-write. The current word comes in on `pin_in`. The registered result goes out on `pin_out`, one clock after the inputs are sampled. Only the target select field changes, and every other bit is carried through. A 2-bit setting chooses how many multiplexer inputs the select fields cycle through, or switches the stepping off.

The block also keeps a half-word flag. It flips on every conversion, because two consecutive channels share one 32-bit output word.

Top module: `mux_seq_top`

## Requirements
- R1: While `rst` is high at a clock edge, `pin_out` and `half_sel` become 0.
- R2: At an edge where `smp_done` is low, `pin_out` takes the value of `pin_in` unchanged.
- R3: With `mux_cfg` = 0 (stepping off), a strobe passes `pin_in` to `pin_out` unchanged.
- R4: The bank A select field is `pin_out[2:0]`. It advances on a strobe whose `scan_chan` is 3 and whose `mux_cfg` is not 0.
- R5: The bank B select field is `pin_out[5:3]`. It advances on a strobe whose `scan_chan` is 7 and whose `mux_cfg` is not 0.
- R6: A strobe with any other `scan_chan` value leaves both select fields equal to those of `pin_in`.
- R7: With `mux_cfg` = 3 (eight inputs), an advanced field becomes (old+1) mod 8, so 7 wraps to 0.
- R8: With `mux_cfg` = 2 (four inputs), an advanced field becomes (old+1) AND 3.
- R9: With `mux_cfg` = 1 (two inputs), an advanced field becomes (old+1) AND 1.
- R10: Bits outside the advanced field are copied from `pin_in`, including the other bank's field and bits 31:6.
- R11: A field value above the configured range is brought back into range by the next advance, for example 6 with `mux_cfg` = 1 gives 1.
- R12: `half_sel` inverts at every edge where `smp_done` is high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_done | input | 1 | One-cycle strobe: an ADC channel has just been read |
| scan_chan | input | 3 | Index of the channel just read |
| mux_cfg | input | 2 | 0 off, 1 two inputs, 2 four inputs, 3 eight inputs |
| pin_in | input | 32 | Current pin word |
| pin_out | output | 32 | Registered updated pin word |
| half_sel | output | 1 | High/low half-word select flag |

## Verification
The assertions check the following on every cycle:
- the passthrough when there is no strobe or stepping is off;
- that each bank advances only on its own trigger channel, to (old+1) masked by the configured length;
- that bits above the select fields are preserved;
- the toggling of the half-word flag.

The bench scenarios are needed for the rest:
- the reset values;
- the exact wrap points in each configuration;
- recovery of out-of-range field values after a configuration change;
- behaviour over long random scans, with and without feeding the output word back as the next input.

// File: rtl/mux_seq_pkg.sv
package mux_seq_pkg;
  typedef enum logic [1:0] {
    CFG_OFF   = 2'd0,
    CFG_TWO   = 2'd1,
    CFG_FOUR  = 2'd2,
    CFG_EIGHT = 2'd3
  } mux_cfg_e;
endpackage

// File: rtl/mux_seq_wrap_mask.sv
module mux_seq_wrap_mask #(
  parameter int SEL_W = 3,
  parameter int CFG_W = 2
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [SEL_W-1:0] mask,
  output logic             active
);
  import mux_seq_pkg::*;

  // The configuration value n selects 2**n inputs: the low n bits survive.
  always_comb begin
    for (int i = 0; i < SEL_W; i++) begin
      mask[i] = (i < int'(cfg));
    end
  end

  assign active = (mux_cfg_e'(cfg) != CFG_OFF);
endmodule

// File: rtl/mux_seq_field_step.sv
module mux_seq_field_step #(
  parameter int SEL_W     = 3,
  parameter int CHAN_W    = 3,
  parameter int TRIG_CHAN = 3
) (
  input  logic              strobe,
  input  logic [CHAN_W-1:0] chan,
  input  logic              active,
  input  logic [SEL_W-1:0]  mask,
  input  logic [SEL_W-1:0]  field_in,
  output logic [SEL_W-1:0]  field_out
);
  localparam logic [CHAN_W-1:0] TRIG = CHAN_W'(TRIG_CHAN);

  logic fire;
  assign fire = strobe && active && (chan == TRIG);

  always_comb begin
    field_out = field_in;
    if (fire) begin
      field_out = (field_in + SEL_W'(1)) & mask;
    end
  end
endmodule

// File: rtl/mux_seq_half_flag.sv
module mux_seq_half_flag (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (strobe) begin
      flag <= ~flag;
    end
  end

  // R12
  half_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (flag != $past(flag)));

  // R12
  half_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(flag));
endmodule

// File: rtl/mux_seq_top.sv
module mux_seq_top #(
  parameter int PIN_W       = 32,
  parameter int SEL_W       = 3,
  parameter int CFG_W       = 2,
  parameter int NUM_GROUPS  = 2,
  parameter int GROUP_SPAN  = 4,
  localparam int CHAN_W     = $clog2(NUM_GROUPS * GROUP_SPAN),
  localparam int FIELD_TOP  = NUM_GROUPS * SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_done,
  input  logic [CHAN_W-1:0] scan_chan,
  input  logic [CFG_W-1:0]  mux_cfg,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic              half_sel
);
  logic [SEL_W-1:0]     len_mask;
  logic                 step_on;
  logic [SEL_W-1:0]     fld_next [NUM_GROUPS];
  logic [FIELD_TOP-1:0] fld_pack;
  logic [PIN_W-1:0]     word_next;

  mux_seq_wrap_mask #(.SEL_W(SEL_W), .CFG_W(CFG_W)) u_mask (
    .cfg    (mux_cfg),
    .mask   (len_mask),
    .active (step_on)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
    localparam int TRIG = g * GROUP_SPAN + GROUP_SPAN - 1;

    mux_seq_field_step #(
      .SEL_W(SEL_W), .CHAN_W(CHAN_W), .TRIG_CHAN(TRIG)
    ) u_step (
      .strobe    (smp_done),
      .chan      (scan_chan),
      .active    (step_on),
      .mask      (len_mask),
      .field_in  (pin_in[g*SEL_W +: SEL_W]),
      .field_out (fld_next[g])
    );

    // R4 R5 R7 R8 R9 R11
    bank_adv_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_done && (mux_cfg != '0) && (scan_chan == CHAN_W'(TRIG))) |=>
      (pin_out[g*SEL_W +: SEL_W] ==
       (SEL_W'($past(pin_in[g*SEL_W +: SEL_W]) + SEL_W'(1)) &
        SEL_W'((32'd1 << $past(mux_cfg)) - 32'd1))));

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_done && (scan_chan != CHAN_W'(TRIG))) |=>
      (pin_out[g*SEL_W +: SEL_W] == $past(pin_in[g*SEL_W +: SEL_W])));
  end

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      fld_pack[g*SEL_W +: SEL_W] = fld_next[g];
    end
  end

  if (FIELD_TOP < PIN_W) begin : g_upper
    assign word_next = {pin_in[PIN_W-1:FIELD_TOP], fld_pack};

    // R10
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (pin_out[PIN_W-1:FIELD_TOP] == $past(pin_in[PIN_W-1:FIELD_TOP])));
  end else begin : g_full
    assign word_next = fld_pack[PIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
    end else begin
      pin_out <= word_next;
    end
  end

  mux_seq_half_flag u_half (
    .clk    (clk),
    .rst    (rst),
    .strobe (smp_done),
    .flag   (half_sel)
  );

  // R2
  idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_done |=> (pin_out == $past(pin_in)));

  // R3
  off_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_done && (mux_cfg == '0)) |=> (pin_out == $past(pin_in)));
endmodule

// File: tb/mux_seq_top_test.sv
`timescale 1ns/1ps
module mux_seq_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_done = 1'b0;
  logic [2:0]  scan_chan = '0;
  logic [1:0]  mux_cfg = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic        half_sel;

  int total = 0;
  int bad = 0;
  logic exp_half = 1'b0;

  always #2.5 clk = ~clk;

  mux_seq_top uut (
    .clk(clk), .rst(rst), .smp_done(smp_done), .scan_chan(scan_chan),
    .mux_cfg(mux_cfg), .pin_in(pin_in), .pin_out(pin_out), .half_sel(half_sel)
  );

  function automatic logic [31:0] model(input logic d, input logic [2:0] ch,
                                        input logic [1:0] c, input logic [31:0] p);
    logic [31:0] r;
    logic [2:0] m;
    r = p;
    m = 3'((32'd1 << c) - 32'd1);
    if (d && c != 2'd0) begin
      if (ch == 3'd3) r[2:0] = (p[2:0] + 3'd1) & m;
      if (ch == 3'd7) r[5:3] = (p[5:3] + 3'd1) & m;
    end
    return r;
  endfunction

  function automatic string tag_of(input logic d, input logic [2:0] ch, input logic [1:0] c);
    if (!d) return "R2";
    if (c == 2'd0) return "R3";
    if (ch == 3'd3) return "R4";
    if (ch == 3'd7) return "R5";
    return "R6";
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pin_out actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: half_sel actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic d, input logic [2:0] ch, input logic [1:0] c,
                      input logic [31:0] p, input string tag);
    logic [31:0] e;
    @(negedge clk);
    smp_done = d; scan_chan = ch; mux_cfg = c; pin_in = p;
    e = model(d, ch, c, p);
    if (d) exp_half = ~exp_half;
    @(posedge clk);
    #1;
    check32(tag, pin_out, e);
    check1("R12", half_sel, exp_half);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    // R1: reset with a busy input word and strobes
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pin_in = 32'hFFFF_FFFF; smp_done = 1'b1; mux_cfg = 2'd3; scan_chan = 3'd3;
    end
    @(posedge clk); #1;
    check32("R1", pin_out, 32'h0);
    check1("R1", half_sel, 1'b0);
    @(negedge clk);
    rst = 1'b0; smp_done = 1'b0;

    // R7: eight inputs, 7 wraps to 0, others intact
    step(1'b1, 3'd3, 2'd3, 32'hA5A5_A5C7, "R7");
    step(1'b1, 3'd7, 2'd3, 32'h0000_003A, "R7");
    // R8: four inputs
    step(1'b1, 3'd3, 2'd2, 32'h0000_0003, "R8");
    step(1'b1, 3'd3, 2'd2, 32'h0000_0001, "R8");
    step(1'b1, 3'd7, 2'd2, 32'h0000_0010, "R8");
    // R9: two inputs
    step(1'b1, 3'd3, 2'd1, 32'h0000_0001, "R9");
    step(1'b1, 3'd7, 2'd1, 32'h0000_0000, "R9");
    // R11: out-of-range values pulled back into range
    step(1'b1, 3'd3, 2'd1, 32'h0000_0006, "R11");
    step(1'b1, 3'd7, 2'd2, 32'h0000_0028, "R11");
    // R10: all other bits preserved across a bank B wrap
    step(1'b1, 3'd7, 2'd3, 32'hFFFF_FFFF, "R10");
    step(1'b1, 3'd3, 2'd3, 32'hDEAD_BEEF, "R10");
    // R3: stepping off, trigger channel
    step(1'b1, 3'd3, 2'd0, 32'h1234_5677, "R3");
    // R6: non-trigger channel
    step(1'b1, 3'd5, 2'd3, 32'h0000_003F, "R6");
    // R2: no strobe
    step(1'b0, 3'd3, 2'd3, 32'h0000_0007, "R2");

    // Scan with feedback: pin_out fed back as next pin_in (R4 R5)
    for (int k = 0; k < 64; k++) begin
      logic [31:0] fb;
      fb = pin_out;
      step(1'b1, 3'(k % 8), 2'd3, fb, tag_of(1'b1, 3'(k % 8), 2'd3));
    end

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      logic d;
      logic [2:0] ch;
      logic [1:0] c;
      logic [31:0] p;
      d  = ($urandom % 4) != 0;
      ch = 3'($urandom % 8);
      c  = 2'($urandom % 4);
      p  = (($urandom % 2) == 0) ? pin_out : $urandom;
      step(d, ch, c, p, tag_of(d, ch, c));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule